// File: doc/BRIEF.md
# Miscellaneous Control Register with Set/Clear Aliases

This block is a single 64-bit control and status word placed on a register bus that only takes full 8-byte accesses. Software reaches the word through three word addresses: a direct address that writes and reads the stored value, a combining alias, and a set alias that ORs the write data into the stored value. The register address is the bus byte address shifted right by three.

A parameter selects one of two variants. In the AND variant the combining alias sits at word 0x4021 and ANDs the write data into the stored value. In the CLEAR variant it sits at word 0x6081 and zeroes the word whatever the data. The direct address is 0x4020 or 0x6080 and the set alias is 0x4022 or 0x6082. Only bits 63..48 are kept. Bit 63 drives a level interrupt output. Any access to an offset outside the three aliases has no effect, reads back zero and pulses a flag for one cycle. An access that is not 8 bytes wide is treated the same way.

Data is big-endian: bit 63 of the data bus is the most significant bit of byte lane 0.

Top module: `misc_ctl_reg`

## Requirements
- R1: While reset is high and in the first cycle after it, the stored word is zero, `irq` is 0, `rsp_valid` is 0 and `unimpl` is 0. `req_ready` is 1 whenever reset is low.
- R2: A write to the direct word address stores the write data. A read there returns the stored value on `rsp_rdata` with `rsp_valid` high in the cycle after the request is accepted.
- R3: Every stored result is ANDed with 0xFFFF000000000000, so bits 47..0 always read as zero.
- R4: In the AND variant (VARIANT = VAR_AND), a write to word 0x4021 stores the current value ANDed with the write data.
- R5: In the CLEAR variant (VARIANT = VAR_CLR), a write to word 0x6081 stores zero, whatever the write data.
- R6: A write to the set alias (word 0x4022 or 0x6082) stores the current value ORed with the write data.
- R7: `irq` equals bit 63 of the stored value. It changes in the same cycle as the stored value and stays unchanged when no write is accepted.
- R8: A read of the combining alias or the set alias returns zero, does not raise `unimpl` and changes nothing.
- R9: An access to any other word address changes nothing. A read there returns zero. In both cases `unimpl` is high for exactly the one cycle after acceptance.
- R10: An access with `req_size` other than 3 (8 bytes) is ignored in the same way as R9: no state change, zero read data, one `unimpl` pulse.
- R11: Each accepted read produces exactly one `rsp_valid` cycle. A write produces none.
- R12: Byte address bits 2..0 do not affect which word is decoded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be accepted |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Byte address |
| req_size | input | 2 | log2 of the access size in bytes; only 3 is valid |
| req_wdata | input | 64 | Write data, bit 63 most significant |
| rsp_valid | output | 1 | Read data valid, one cycle per accepted read |
| rsp_rdata | output | 64 | Read data |
| irq | output | 1 | Interrupt level, bit 63 of the stored word |
| unimpl | output | 1 | One-cycle pulse after an unmapped or wrong-size access |

## Verification
The hardest situation to reach is the proof that an ignored access truly did nothing. For unmapped offsets, wrong sizes and reads of aliases, the only sign at the ports is a later read of the direct address. The stimulus therefore first loads a word with bits set on both sides of the 48-bit boundary. It then issues each ignored access with data that would visibly change that word, and reads the direct address back before any other write. Both variants are instantiated side by side. Each one is also sent the other's addresses, so the combining alias of one variant is exercised as an unmapped offset of the other.

// File: rtl/misc_reg_pkg.sv
package misc_reg_pkg;

    localparam int WORD_W    = 64;
    localparam int KEEP_W    = 16;
    localparam int SIZE_W    = 2;
    localparam int FULL_SIZE = 3;
    localparam int OFS_SHIFT = 3;

    typedef enum logic [0:0] {
        VAR_AND = 1'b0,
        VAR_CLR = 1'b1
    } variant_e;

    typedef enum logic [2:0] {
        OP_NONE,
        OP_DIRECT,
        OP_MERGE,
        OP_SET,
        OP_BAD
    } op_e;

    typedef struct packed {
        logic              wr;
        op_e               op;
        logic [WORD_W-1:0] data;
    } cmd_t;

    function automatic logic [WORD_W-1:0] keep_mask();
        logic [WORD_W-1:0] m;
        m = '0;
        for (int i = WORD_W - KEEP_W; i < WORD_W; i++) m[i] = 1'b1;
        return m;
    endfunction

    function automatic logic [31:0] base_word(variant_e v);
        return (v == VAR_AND) ? 32'h0000_4020 : 32'h0000_6080;
    endfunction

endpackage

// File: rtl/misc_dec.sv
module misc_dec
    import misc_reg_pkg::*;
#(
    parameter variant_e VARIANT = VAR_AND,
    parameter int       ADDR_W  = 24
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [SIZE_W-1:0] size,
    output op_e               op
);
    localparam int WADDR_W = ADDR_W - OFS_SHIFT;
    localparam logic [31:0] BASE = base_word(VARIANT);

    logic [31:0] word;

    always_comb begin
        word = 32'(addr[ADDR_W-1:OFS_SHIFT]);
        if (size != SIZE_W'(FULL_SIZE)) begin
            op = OP_BAD;
        end else if (word == BASE) begin
            op = OP_DIRECT;
        end else if (word == BASE + 32'd1) begin
            op = OP_MERGE;
        end else if (word == BASE + 32'd2) begin
            op = OP_SET;
        end else begin
            op = OP_BAD;
        end
    end

    if (WADDR_W < 16) begin : g_width_chk
        initial $error("ADDR_W too small for the word offsets");
    end
endmodule

// File: rtl/misc_upd.sv
module misc_upd
    import misc_reg_pkg::*;
#(
    parameter variant_e VARIANT = VAR_AND
) (
    input  cmd_t              cmd,
    input  logic [WORD_W-1:0] cur,
    output logic              we,
    output logic [WORD_W-1:0] nxt
);
    localparam logic [WORD_W-1:0] MASK = keep_mask();

    logic [WORD_W-1:0] raw;
    logic [WORD_W-1:0] merged;

    if (VARIANT == VAR_AND) begin : g_and
        assign merged = cur & cmd.data;
    end else begin : g_clr
        assign merged = '0;
    end

    always_comb begin
        we  = 1'b0;
        raw = cur;
        if (cmd.wr) begin
            unique case (cmd.op)
                OP_DIRECT: begin we = 1'b1; raw = cmd.data;       end
                OP_MERGE:  begin we = 1'b1; raw = merged;         end
                OP_SET:    begin we = 1'b1; raw = cur | cmd.data; end
                default:   begin we = 1'b0; raw = cur;            end
            endcase
        end
        nxt = raw & MASK;
    end
endmodule

// File: rtl/misc_store.sv
module misc_store
    import misc_reg_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [WORD_W-1:0] nxt,
    output logic [WORD_W-1:0] val,
    output logic              irq
);
    always_ff @(posedge clk) begin
        if (rst) begin
            val <= '0;
            irq <= 1'b0;
        end else if (we) begin
            val <= nxt;
            irq <= nxt[WORD_W-1];
        end
    end
endmodule

// File: rtl/misc_ctl_reg.sv
module misc_ctl_reg
    import misc_reg_pkg::*;
#(
    parameter variant_e VARIANT = VAR_AND,
    parameter int       ADDR_W  = 24
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [1:0]        req_size,
    input  logic [63:0]       req_wdata,
    output logic              rsp_valid,
    output logic [63:0]       rsp_rdata,
    output logic              irq,
    output logic              unimpl
);
    op_e               op;
    cmd_t              cmd;
    logic              acc;
    logic              we;
    logic [WORD_W-1:0] nxt;
    logic [WORD_W-1:0] val;

    assign req_ready = ~rst;
    assign acc       = req_valid & req_ready;

    misc_dec #(.VARIANT(VARIANT), .ADDR_W(ADDR_W)) u_dec (
        .addr (req_addr),
        .size (req_size),
        .op   (op)
    );

    always_comb begin
        cmd.wr   = acc & req_write;
        cmd.op   = acc ? op : OP_NONE;
        cmd.data = req_wdata;
    end

    misc_upd #(.VARIANT(VARIANT)) u_upd (
        .cmd (cmd),
        .cur (val),
        .we  (we),
        .nxt (nxt)
    );

    misc_store u_store (
        .clk (clk),
        .rst (rst),
        .we  (we),
        .nxt (nxt),
        .val (val),
        .irq (irq)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid <= 1'b0;
            rsp_rdata <= '0;
            unimpl    <= 1'b0;
        end else begin
            rsp_valid <= acc & ~req_write;
            rsp_rdata <= (acc && !req_write && op == OP_DIRECT) ? val : '0;
            unimpl    <= acc & (op == OP_BAD);
        end
    end
endmodule

// File: rtl/misc_ctl_reg_chk.sv
module misc_ctl_reg_chk (
    input logic        clk,
    input logic        rst,
    input logic        req_valid,
    input logic        req_ready,
    input logic        req_write,
    input logic        rsp_valid,
    input logic [63:0] rsp_rdata,
    input logic        irq,
    input logic        unimpl
);
    // R3
    low_bits_zero_chk: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |-> (rsp_rdata[47:0] == 48'd0));

    // R11
    read_rsp_chk: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready && !req_write) |=> rsp_valid);

    // R11
    no_spurious_rsp_chk: assert property (@(posedge clk) disable iff (rst)
        !(req_valid && req_ready && !req_write) |=> !rsp_valid);

    // R9
    flag_needs_access_chk: assert property (@(posedge clk) disable iff (rst)
        !(req_valid && req_ready) |=> !unimpl);

    // R7
    irq_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !(req_valid && req_ready && req_write) |=> $stable(irq));

    // R1
    ready_chk: assert property (@(posedge clk) disable iff (rst)
        req_ready);
endmodule

bind misc_ctl_reg misc_ctl_reg_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .req_write (req_write),
    .rsp_valid (rsp_valid),
    .rsp_rdata (rsp_rdata),
    .irq       (irq),
    .unimpl    (unimpl)
);

// File: tb/tb_misc_ctl_reg.sv
module tb_misc_ctl_reg;
    import misc_reg_pkg::*;

    localparam logic [63:0] M = 64'hFFFF_0000_0000_0000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        va = 1'b0, vb = 1'b0, wr = 1'b0;
    logic [23:0] addr = '0;
    logic [1:0]  size = 2'd3;
    logic [63:0] wd = '0;
    logic        rdy_a, rdy_b, rv_a, rv_b, irq_a, irq_b, un_a, un_b;
    logic [63:0] rd_a, rd_b;

    int n_chk = 0;
    int n_fail = 0;
    logic [63:0] mdl_a = '0, mdl_b = '0;
    logic [63:0] qd_a[$], qd_b[$];
    string       qt_a[$], qt_b[$];

    always #5 clk = ~clk;

    misc_ctl_reg #(.VARIANT(VAR_AND), .ADDR_W(24)) dut (
        .clk(clk), .rst(rst), .req_valid(va), .req_ready(rdy_a), .req_write(wr),
        .req_addr(addr), .req_size(size), .req_wdata(wd), .rsp_valid(rv_a),
        .rsp_rdata(rd_a), .irq(irq_a), .unimpl(un_a));

    misc_ctl_reg #(.VARIANT(VAR_CLR), .ADDR_W(24)) dut_clr (
        .clk(clk), .rst(rst), .req_valid(vb), .req_ready(rdy_b), .req_write(wr),
        .req_addr(addr), .req_size(size), .req_wdata(wd), .rsp_valid(rv_b),
        .rsp_rdata(rd_b), .irq(irq_b), .unimpl(un_b));

    task automatic check(input string rq, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", rq, act, exp);
        end
    endtask

    // Monitors: pop expected read data as responses arrive (R11: none unexpected)
    always @(negedge clk) begin
        if (!rst && rv_a) begin
            if (qd_a.size() == 0) check("R11 unexpected rsp A", 64'd1, 64'd0);
            else check(qt_a.pop_front(), rd_a, qd_a.pop_front());
        end
        if (!rst && rv_b) begin
            if (qd_b.size() == 0) check("R11 unexpected rsp B", 64'd1, 64'd0);
            else check(qt_b.pop_front(), rd_b, qd_b.pop_front());
        end
    end

    // One access on instance b (0 = AND variant, 1 = CLEAR variant).
    // Caller updates the model before the call; exp_rd is the expected read data.
    task automatic acc(input bit b, input bit w, input logic [23:0] word, input logic [2:0] low,
                       input logic [1:0] sz, input logic [63:0] d, input logic [63:0] exp_rd,
                       input bit exp_flag, input string rq);
        @(negedge clk);
        wr = w; addr = {word[20:0], low}; size = sz; wd = d;
        if (b) vb = 1'b1; else va = 1'b1;
        if (!w) begin
            if (b) begin qd_b.push_back(exp_rd); qt_b.push_back(rq); end
            else   begin qd_a.push_back(exp_rd); qt_a.push_back(rq); end
        end
        @(negedge clk);
        va = 1'b0; vb = 1'b0;
        check({rq, " flag"}, 64'(b ? un_b : un_a), 64'(exp_flag));
        check({rq, " irq"}, 64'(b ? irq_b : irq_a), 64'(b ? mdl_b[63] : mdl_a[63]));
    endtask

    task automatic readback(input bit b, input string rq);
        acc(b, 1'b0, b ? 24'h6080 : 24'h4020, 3'd0, 2'd3, '0, b ? mdl_b : mdl_a, 1'b0, rq);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1: state during reset
        check("R1 irq in reset", 64'(irq_a | irq_b), 64'd0);
        check("R1 rsp in reset", 64'(rv_a | rv_b | un_a | un_b), 64'd0);
        rst = 1'b0;
        @(negedge clk);
        check("R1 ready", 64'(rdy_a & rdy_b), 64'd1);
        check("R1 flags after reset", 64'(un_a | un_b | rv_a | rv_b | irq_a | irq_b), 64'd0);
        readback(0, "R1 reset value A");
        readback(1, "R1 reset value B");

        // R2 R3 R7: direct write, masked, irq rises
        mdl_a = 64'hDEAD_BEEF_1234_5678 & M;
        acc(0, 1, 24'h4020, 3'd0, 2'd3, 64'hDEAD_BEEF_1234_5678, '0, 0, "R2 direct write");
        readback(0, "R2 R3 direct read");

        // R4: AND alias
        mdl_a = mdl_a & 64'h8F0F_FFFF_FFFF_FFFF & M;
        acc(0, 1, 24'h4021, 3'd0, 2'd3, 64'h8F0F_FFFF_FFFF_FFFF, '0, 0, "R4 and alias");
        readback(0, "R4 after and");

        // R6: OR alias on A
        mdl_a = (mdl_a | 64'h0031_0000_FFFF_0000) & M;
        acc(0, 1, 24'h4022, 3'd0, 2'd3, 64'h0031_0000_FFFF_0000, '0, 0, "R6 or alias A");
        readback(0, "R6 after or A");

        // R7: clearing bit 63 through AND drops irq
        mdl_a = mdl_a & 64'h7FFF_FFFF_FFFF_FFFF;
        acc(0, 1, 24'h4021, 3'd0, 2'd3, 64'h7FFF_FFFF_FFFF_FFFF, '0, 0, "R7 irq falls");
        readback(0, "R7 value after irq fall");

        // R8: reads of aliases return zero, no flag, no change
        acc(0, 0, 24'h4021, 3'd0, 2'd3, '0, '0, 0, "R8 read and alias");
        acc(0, 0, 24'h4022, 3'd0, 2'd3, '0, '0, 0, "R8 read or alias");
        readback(0, "R8 unchanged");

        // R9: unmapped write and read
        acc(0, 1, 24'h4023, 3'd0, 2'd3, 64'hFFFF_FFFF_FFFF_FFFF, '0, 1, "R9 unmapped write");
        acc(0, 1, 24'h6082, 3'd0, 2'd3, 64'hFFFF_FFFF_FFFF_FFFF, '0, 1, "R9 foreign alias write");
        acc(0, 0, 24'h401F, 3'd0, 2'd3, '0, '0, 1, "R9 unmapped read");
        readback(0, "R9 unchanged");
        @(negedge clk);
        check("R9 flag one cycle", 64'(un_a), 64'd0);

        // R10: wrong size ignored
        acc(0, 1, 24'h4020, 3'd0, 2'd2, 64'hFFFF_FFFF_FFFF_FFFF, '0, 1, "R10 size4 write");
        acc(0, 0, 24'h4020, 3'd0, 2'd0, '0, '0, 1, "R10 size1 read");
        readback(0, "R10 unchanged");

        // R12: low address bits ignored
        mdl_a = 64'h8001_0000_0000_0000;
        acc(0, 1, 24'h4020, 3'd5, 2'd3, 64'h8001_0000_0000_0000, '0, 0, "R12 offset write");
        acc(0, 0, 24'h4020, 3'd7, 2'd3, '0, mdl_a, 0, "R12 offset read");

        // Variant B: R5 clear ignores data, R6 OR
        mdl_b = M;
        acc(1, 1, 24'h6080, 3'd0, 2'd3, 64'hFFFF_FFFF_FFFF_FFFF, '0, 0, "R3 B direct");
        readback(1, "R3 B masked");
        mdl_b = '0;
        acc(1, 1, 24'h6081, 3'd0, 2'd3, 64'hFFFF_FFFF_FFFF_FFFF, '0, 0, "R5 clear alias");
        readback(1, "R5 after clear");
        mdl_b = 64'h8000_0000_0000_0000;
        acc(1, 1, 24'h6082, 3'd0, 2'd3, 64'h8000_0000_0000_1234, '0, 0, "R6 or alias B");
        mdl_b = 64'h8400_0000_0000_0000;
        acc(1, 1, 24'h6082, 3'd0, 2'd3, 64'h0400_0000_0000_0000, '0, 0, "R6 or accumulates B");
        readback(1, "R6 after or B");
        acc(1, 1, 24'h4021, 3'd0, 2'd3, '0, '0, 1, "R9 B foreign and alias");
        acc(1, 0, 24'h6081, 3'd0, 2'd3, '0, '0, 0, "R8 B read clear alias");
        readback(1, "R9 B unchanged");

        repeat (3) @(negedge clk);
        check("R11 all responses seen", 64'(qd_a.size() + qd_b.size()), 64'd0);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule